// File: doc/BRIEF.md
# Token-Ring Polled Status Sequencer

This block drives one device's share of an 8-bit almost-empty status bus that several devices have in common. The device's 32 per-queue status bits are split into four quadrants of eight. While the device owns the bus it shows one quadrant per read-clock cycle, in the order 0, 1, 2, 3. During its last quadrant it hands ownership to the next device in a ring through a single-cycle token. A sync marker flags the cycle in which the device's quadrant 0 is on the bus, so a receiver can align itself to each device's turn.

The operating mode and the master role are set by two strap inputs, which are sampled while the active-low master reset is held. Only the device strapped as master starts with the bus. Every other device waits, with its bus disabled, until the token arrives. A device used on its own closes the ring by feeding its token output back to its own token input, and then polls its quadrants without a break. Instead of a high-impedance state, the block drives its bus lines to zero whenever it does not own the bus and reports ownership on a separate enable. The shared bus is then the OR of all devices' bus outputs.

Top module: `ring_poll_seq`

## Requirements
- R1: If `mode_i` is low while reset is held, the block stays inert after reset. `bus_en_o`, `sync_o` and `tok_o` remain low, and `tok_i` has no effect.
- R2: If `mode_i` and `mast_i` are both high during reset, the block takes the bus at the first rising clock edge after `rst_n` goes high and shows quadrant 0 from that edge. A device with `mast_i` low stays idle after reset, with `bus_en_o` low.
- R3: An owning device shows quadrants 0, 1, 2 and 3 on four consecutive cycles. The value of quadrant k is `stat_i[8k+7:8k]`, as sampled at the clock edge that starts that cycle. After quadrant 3 the device drops `bus_en_o`, unless it takes the token at that same edge.
- R4: `bus_o` is all zeros whenever `bus_en_o` is low, including during reset.
- R5: `sync_o` is high exactly in the cycle in which the device's quadrant 0 is on the bus.
- R6: `tok_o` is a single-cycle pulse that is high exactly in the device's quadrant 3 cycle.
- R7: An idle device in polled mode that samples `tok_i` high at a rising edge owns the bus from that edge, starting with quadrant 0. A device whose `tok_o` is looped back to its `tok_i` repeats quadrants 0 to 3 with no idle cycle between turns.
- R8: `tok_i` high during quadrants 0 to 2 of the device's own turn is ignored. The turn neither restarts nor lengthens.
- R9: When several devices form a ring (each `tok_o` drives the next device's `tok_i`, and the last drives the master's), exactly one device has `bus_en_o` high in every cycle after the master's first edge. The devices take turns in ring order, starting with the master.
- R10: Changes on `mode_i` or `mast_i` after reset is released have no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Read clock, rising edge active |
| rst_n | input | 1 | Master reset, active low, asserted asynchronously |
| mode_i | input | 1 | Mode strap, sampled during reset; high selects polled operation |
| mast_i | input | 1 | Master strap, sampled during reset; high makes this device the first owner |
| tok_i | input | 1 | Ownership token from the previous device in the ring |
| stat_i | input | 32 | Per-queue almost-empty status, queue n at bit n |
| bus_o | output | 8 | Status quadrant currently shown; zero when the bus is not owned |
| bus_en_o | output | 1 | High while this device owns the shared status bus |
| sync_o | output | 1 | High in the cycle in which quadrant 0 of this device is on the bus |
| tok_o | output | 1 | Token pulse to the next device, high in the quadrant 3 cycle |

## Verification
The bench uses the default parameters: 8-bit quadrants and four quadrants per device, which gives a 2-bit quadrant counter that wraps at the turn boundary. Three instances wired as a ring make the hand-off from the last device back to the master happen twice within one short run, and each device has its own distinct status pattern, so the order of ownership is visible on the OR-ed bus. A fourth instance has a token input that the bench drives or loops back. On it the bench tests non-master start-up, a token arriving in the middle of a turn, a status change in the middle of a turn, continuous loopback polling and the inert mode.

// File: rtl/rps_pkg.sv
`timescale 1ns/1ps
package rps_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_OWN  = 1'b1
  } own_e;

endpackage

// File: rtl/rps_strap.sv
`timescale 1ns/1ps
// Captures the straps on every clock edge while reset is held, and flags
// the first cycle after reset release.
module rps_strap (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_i,
  input  logic mast_i,
  output logic poll_q,
  output logic mast_q,
  output logic boot_q
);

  logic cap_en;
  logic boot_nxt;

  assign cap_en   = !rst_n;
  assign boot_nxt = 1'b0;

  // Strap registers: loaded only while reset is held, no reset of their own.
  always_ff @(posedge clk) begin
    if (cap_en) begin
      poll_q <= mode_i;
      mast_q <= mast_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boot_q <= 1'b1;
    end else begin
      boot_q <= boot_nxt;
    end
  end

endmodule

// File: rtl/rps_turn.sv
`timescale 1ns/1ps
// Ownership state and quadrant counter of one device.
module rps_turn #(
  parameter int NQUAD = 4,
  parameter int QW    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          poll_i,
  input  logic          kick_i,
  input  logic          tok_i,
  output logic          own_nxt_o,
  output logic [QW-1:0] quad_nxt_o,
  output logic          own_o,
  output logic          sync_o,
  output logic          tok_o
);
  import rps_pkg::*;

  localparam logic [QW-1:0] QLAST = QW'(NQUAD - 1);

  own_e          st_q, st_nxt;
  logic [QW-1:0] quad_q, quad_nxt;
  logic          last;
  logic          take;

  always_comb begin
    last = (st_q == ST_OWN) && (quad_q == QLAST);
    take = poll_i && (kick_i || (tok_i && ((st_q == ST_IDLE) || last)));
    if ((st_q == ST_OWN) && !last) begin
      st_nxt   = ST_OWN;
      quad_nxt = quad_q + 1'b1;
    end else if (take) begin
      st_nxt   = ST_OWN;
      quad_nxt = '0;
    end else begin
      st_nxt   = ST_IDLE;
      quad_nxt = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      quad_q <= '0;
    end else begin
      st_q   <= st_nxt;
      quad_q <= quad_nxt;
    end
  end

  assign own_nxt_o  = (st_nxt == ST_OWN);
  assign quad_nxt_o = quad_nxt;
  assign own_o      = (st_q == ST_OWN);
  assign sync_o     = (st_q == ST_OWN) && (quad_q == '0);
  assign tok_o      = last;

endmodule

// File: rtl/rps_outreg.sv
`timescale 1ns/1ps
// Selects the next quadrant slice and registers it onto the bus.
module rps_outreg #(
  parameter int W     = 8,
  parameter int NQUAD = 4,
  parameter int QW    = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ld_i,
  input  logic [QW-1:0]  sel_i,
  input  logic [W*NQUAD-1:0] stat_i,
  output logic [W-1:0]   bus_o
);

  logic [W-1:0] slice [NQUAD];
  logic [W-1:0] bus_nxt;

  for (genvar g = 0; g < NQUAD; g++) begin : g_slice
    assign slice[g] = stat_i[g*W +: W];
  end

  always_comb begin
    bus_nxt = ld_i ? slice[sel_i] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_o <= '0;
    end else begin
      bus_o <= bus_nxt;
    end
  end

endmodule

// File: rtl/ring_poll_seq.sv
`timescale 1ns/1ps
module ring_poll_seq #(
  parameter int W     = 8,
  parameter int NQUAD = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_i,
  input  logic             mast_i,
  input  logic             tok_i,
  input  logic [W*NQUAD-1:0] stat_i,
  output logic [W-1:0]     bus_o,
  output logic             bus_en_o,
  output logic             sync_o,
  output logic             tok_o
);

  localparam int QW = (NQUAD > 1) ? $clog2(NQUAD) : 1;

  logic          poll_q;
  logic          mast_q;
  logic          boot_q;
  logic          kick;
  logic          own_nxt;
  logic [QW-1:0] quad_nxt;

  assign kick = boot_q && mast_q;

  rps_strap u_strap (
    .clk    (clk),
    .rst_n  (rst_n),
    .mode_i (mode_i),
    .mast_i (mast_i),
    .poll_q (poll_q),
    .mast_q (mast_q),
    .boot_q (boot_q)
  );

  rps_turn #(.NQUAD(NQUAD), .QW(QW)) u_turn (
    .clk        (clk),
    .rst_n      (rst_n),
    .poll_i     (poll_q),
    .kick_i     (kick),
    .tok_i      (tok_i),
    .own_nxt_o  (own_nxt),
    .quad_nxt_o (quad_nxt),
    .own_o      (bus_en_o),
    .sync_o     (sync_o),
    .tok_o      (tok_o)
  );

  rps_outreg #(.W(W), .NQUAD(NQUAD), .QW(QW)) u_out (
    .clk    (clk),
    .rst_n  (rst_n),
    .ld_i   (own_nxt),
    .sel_i  (quad_nxt),
    .stat_i (stat_i),
    .bus_o  (bus_o)
  );

endmodule

// File: rtl/rps_checker.sv
`timescale 1ns/1ps
module rps_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         poll_q,
  input logic         tok_i,
  input logic [W-1:0] stat_lo,
  input logic [W-1:0] bus_o,
  input logic         bus_en_o,
  input logic         sync_o,
  input logic         tok_o
);

  a_r1_inert: assert property (@(posedge clk) disable iff (!rst_n)
    !poll_q |-> !bus_en_o);

  a_r3_hold_turn: assert property (@(posedge clk) disable iff (!rst_n)
    bus_en_o && !tok_o |=> bus_en_o);

  a_r3_release: assert property (@(posedge clk) disable iff (!rst_n)
    tok_o && !tok_i |=> !bus_en_o);

  a_r3_first_slice: assert property (@(posedge clk) disable iff (!rst_n)
    sync_o |-> bus_o == $past(stat_lo));

  a_r4_bus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_en_o |-> bus_o == '0);

  a_r5_sync_owned: assert property (@(posedge clk) disable iff (!rst_n)
    sync_o |-> bus_en_o);

  a_r5_sync_single: assert property (@(posedge clk) disable iff (!rst_n)
    sync_o |=> !sync_o);

  a_r6_tok_single: assert property (@(posedge clk) disable iff (!rst_n)
    tok_o |=> !tok_o);

  a_r6_tok_late: assert property (@(posedge clk) disable iff (!rst_n)
    tok_o |-> bus_en_o && !sync_o);

  a_r7_take: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_en_o || tok_o) && tok_i && poll_q |=> sync_o);

  a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    bus_en_o && !tok_o |=> !sync_o);

endmodule

bind ring_poll_seq rps_checker #(.W(W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .poll_q   (poll_q),
  .tok_i    (tok_i),
  .stat_lo  (stat_i[W-1:0]),
  .bus_o    (bus_o),
  .bus_en_o (bus_en_o),
  .sync_o   (sync_o),
  .tok_o    (tok_o)
);

// File: tb/test_ring_poll_seq.sv
`timescale 1ns/1ps
module test_ring_poll_seq;

  localparam int W    = 8;
  localparam int NQ   = 4;
  localparam int SW   = W * NQ;
  localparam int NDEV = 3;
  localparam int NEXP = NDEV * NQ;

  // Expected ownership per cycle: {device[1:0], quadrant[1:0]}.
  localparam logic [3:0] EXP_TAB [NEXP] = '{
    4'h0, 4'h1, 4'h2, 4'h3,
    4'h4, 4'h5, 4'h6, 4'h7,
    4'h8, 4'h9, 4'hA, 4'hB
  };

  function automatic logic [W-1:0] byte_of(int d, int q);
    return W'((d + 1) * 16 + q + 5);
  endfunction

  function automatic logic [SW-1:0] stat_of(int d);
    logic [SW-1:0] v;
    for (int q = 0; q < NQ; q++) v[q*W +: W] = byte_of(d, q);
    return v;
  endfunction

  function automatic logic [W-1:0] sl(logic [SW-1:0] v, int q);
    return v[q*W +: W];
  endfunction

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;

  // Ring of NDEV devices, device 0 is master.
  logic [NDEV-1:0] r_tok, r_en, r_sync;
  logic [W-1:0]    r_bus [NDEV];

  for (genvar k = 0; k < NDEV; k++) begin : g_ring
    localparam logic [SW-1:0] STAT = stat_of(k);
    ring_poll_seq #(.W(W), .NQUAD(NQ)) i_ring_poll_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode_i   (1'b1),
      .mast_i   (k == 0),
      .tok_i    (r_tok[(k + NDEV - 1) % NDEV]),
      .stat_i   (STAT),
      .bus_o    (r_bus[k]),
      .bus_en_o (r_en[k]),
      .sync_o   (r_sync[k]),
      .tok_o    (r_tok[k])
    );
  end

  logic [W-1:0] ring_bus;
  int           ring_cnt;
  int           owner;
  always_comb begin
    ring_bus = '0;
    ring_cnt = 0;
    owner    = 0;
    for (int k = 0; k < NDEV; k++) begin
      ring_bus = ring_bus | r_bus[k];
      if (r_en[k]) begin
        ring_cnt = ring_cnt + 1;
        owner    = k;
      end
    end
  end

  // Stand-alone device with a bench-controlled token input.
  logic          d_mode, d_mast, d_loop, d_force;
  logic [SW-1:0] d_stat;
  logic [W-1:0]  d_bus;
  logic          d_en, d_sync, d_tokout, d_tok;
  assign d_tok = d_loop ? d_tokout : d_force;

  ring_poll_seq #(.W(W), .NQUAD(NQ)) i_ring_poll_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_i   (d_mode),
    .mast_i   (d_mast),
    .tok_i    (d_tok),
    .stat_i   (d_stat),
    .bus_o    (d_bus),
    .bus_en_o (d_en),
    .sync_o   (d_sync),
    .tok_o    (d_tokout)
  );

  task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic mode, input logic mast, input logic loop);
    @(negedge clk);
    rst_n   = 1'b0;
    d_mode  = mode;
    d_mast  = mast;
    d_loop  = loop;
    d_force = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  localparam logic [SW-1:0] STAT_A = 32'hC3B2A190;
  localparam logic [SW-1:0] STAT_B = 32'h5E4D3C2B;

  initial begin
    rst_n   = 1'b0;
    d_mode  = 1'b1;
    d_mast  = 1'b0;
    d_loop  = 1'b0;
    d_force = 1'b0;
    d_stat  = STAT_A;
    repeat (3) @(negedge clk);

    // R4: reset state
    chk_eq("R4 reset ring enables", 32'(r_en), 32'd0);
    chk_eq("R4 reset ring bus", 32'(ring_bus), 32'd0);
    chk_eq("R4 reset ring sync/tok", 32'({r_sync, r_tok}), 32'd0);
    chk_eq("R4 reset solo outputs", 32'({d_bus, d_en, d_sync, d_tokout}), 32'd0);

    rst_n = 1'b1;
    @(negedge clk);

    // Ring walk: two laps through the expectation table (R9, R3, R5, R6).
    for (int i = 0; i < 2 * NEXP; i++) begin
      logic [3:0] ent;
      int dv, qd;
      ent = EXP_TAB[i % NEXP];
      dv  = int'(ent[3:2]);
      qd  = int'(ent[1:0]);
      chk_eq("R9 single owner", 32'(ring_cnt), 32'd1);
      chk_eq("R9 owner order", 32'(owner), 32'(dv));
      chk_eq("R3 ring quadrant value", 32'(ring_bus), 32'(byte_of(dv, qd)));
      chk_eq("R5 ring sync", 32'(r_sync), (qd == 0) ? 32'(1 << dv) : 32'd0);
      chk_eq("R6 ring token", 32'(r_tok), (qd == 3) ? 32'(1 << dv) : 32'd0);
      @(negedge clk);
    end

    // Non-master start, strap change after reset, token mid-turn.
    d_stat = STAT_A;
    do_reset(1'b1, 1'b0, 1'b0);
    chk_eq("R2 non-master idle", 32'(d_en), 32'd0);
    chk_eq("R4 idle bus zero", 32'(d_bus), 32'd0);
    d_mast = 1'b1;
    @(negedge clk);
    chk_eq("R10 late master strap", 32'(d_en), 32'd0);
    @(negedge clk);
    chk_eq("R10 late master strap", 32'(d_en), 32'd0);
    d_force = 1'b1;
    @(negedge clk);
    chk_eq("R7 token take enable", 32'(d_en), 32'd1);
    chk_eq("R7 token take sync", 32'(d_sync), 32'd1);
    chk_eq("R7 token take quadrant 0", 32'(d_bus), 32'(sl(STAT_A, 0)));
    @(negedge clk);
    chk_eq("R8 mid-turn token no restart", 32'(d_sync), 32'd0);
    chk_eq("R8 quadrant 1", 32'(d_bus), 32'(sl(STAT_A, 1)));
    d_force = 1'b0;
    d_stat  = STAT_B;
    @(negedge clk);
    chk_eq("R3 status sampled at edge", 32'(d_bus), 32'(sl(STAT_B, 2)));
    chk_eq("R6 no token in quadrant 2", 32'(d_tokout), 32'd0);
    @(negedge clk);
    chk_eq("R3 quadrant 3", 32'(d_bus), 32'(sl(STAT_B, 3)));
    chk_eq("R6 token in quadrant 3", 32'(d_tokout), 32'd1);
    @(negedge clk);
    chk_eq("R3 release after turn", 32'(d_en), 32'd0);
    chk_eq("R4 bus zero after turn", 32'(d_bus), 32'd0);
    chk_eq("R6 token single pulse", 32'(d_tokout), 32'd0);

    // Master with loopback: continuous polling.
    d_stat = STAT_A;
    do_reset(1'b1, 1'b1, 1'b1);
    chk_eq("R2 master first edge enable", 32'(d_en), 32'd1);
    chk_eq("R2 master first edge sync", 32'(d_sync), 32'd1);
    chk_eq("R2 master quadrant 0", 32'(d_bus), 32'(sl(STAT_A, 0)));
    for (int i = 1; i < 12; i++) begin
      @(negedge clk);
      chk_eq("R7 loopback enable", 32'(d_en), 32'd1);
      chk_eq("R7 loopback quadrant", 32'(d_bus), 32'(sl(STAT_A, i % NQ)));
      chk_eq("R5 loopback sync", 32'(d_sync), (i % NQ == 0) ? 32'd1 : 32'd0);
    end

    // Inert mode.
    do_reset(1'b0, 1'b1, 1'b0);
    chk_eq("R1 inert after reset", 32'(d_en), 32'd0);
    d_mode  = 1'b1;
    d_force = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk_eq("R1 inert outputs", 32'({d_en, d_sync, d_tokout}), 32'd0);
      chk_eq("R10 late mode strap bus", 32'(d_bus), 32'd0);
    end
    d_force = 1'b0;

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog (R1..R10 run): actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule